// File: doc/BRIEF.md
# Multidrop Serial Receiver with Address Sleep

This block receives asynchronous NRZ characters from a single serial line. A falling edge starts a frame. The start bit is then confirmed at its centre, and every later bit is sampled at its centre by a clock counter that restarts on each start edge. The framing is programmable:

- 1 to 8 data bits, least significant first.
- An optional parity bit, odd or even.
- An optional address tag bit, used in tag mode.
- One or two stop bits.

The bit period is set by a baud setting. The received character is kept right-aligned in an output register. Parity, framing and address flags are latched with the character.

On a multidrop bus, a node sets `sleep` so that it ignores traffic meant for other nodes. While asleep, the block delivers only frames identified as addresses. Two rules identify an address frame:

- **Tag mode:** the extra bit after the data and parity is 1.
- **Idle-gap mode:** the frame follows a quiet period of at least ten bit times on the line.

Data frames that arrive while asleep leave no trace. Once the address is recognised as its own, the surrounding logic clears `sleep`, and the block then hands over every frame until `sleep` is set again. A character that completes while the previous one is still unread sets a sticky overrun flag.

Top module: `uart_addr_rx`

## Requirements
- R1: After reset, rx_ready, rx_full, rx_overrun, rx_par_err, rx_frm_err, rx_addr are 0 and rx_data is 0.
- R2: A frame is a low start bit, cfg_len_m1+1 data bits sent LSB first, an optional parity bit (cfg_par_en=1), an optional tag bit (cfg_addr_mode=1), then one stop bit (cfg_two_stop=0) or two (cfg_two_stop=1). A delivered character appears in rx_data right-aligned with the unused upper bits 0. It raises rx_ready for exactly one cycle and sets rx_full, which rd_ack clears.
- R3: One bit period is 16 clocks when cfg_baud is 0, otherwise (cfg_baud+1)*8 clocks. rx_ready rises 4 + P/2 + (F-1)*P clocks after the clock cycle in which the line falls, where P is the bit period and F is the number of bits in the frame including start and stop bits.
- R4: With cfg_par_en=1, the expected parity bit is 1 for odd parity (cfg_par_odd=1) when the data holds an even number of ones, and 0 for even parity (cfg_par_odd=0) in that case. rx_par_err is 1 when the received bit differs from the expected bit. With cfg_par_en=0, rx_par_err is 0.
- R5: rx_frm_err is 1 when any stop bit is sampled low.
- R6: A low pulse that is already high again at the start bit's centre is discarded: no rx_ready, no change to rx_full, and the next valid frame is received correctly.
- R7: In tag mode (cfg_addr_mode=1), rx_addr equals the tag bit of the delivered frame.
- R8: In idle-gap mode (cfg_addr_mode=0), rx_addr is 1 when the line was high for at least 10 whole bit periods after the receiver went idle and before the start edge, otherwise 0.
- R9: While sleep=1, a frame whose address indication is 0 raises no rx_ready and leaves rx_data and rx_full unchanged. A frame whose address indication is 1 is delivered.
- R10: While sleep=0, every frame is delivered whatever its address indication.
- R11: A character delivered while rx_full=1 and rd_ack=0 sets rx_overrun. It stays set until rd_ack is asserted, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial line, idle high |
| cfg_baud | input | DIV_W | Baud setting; 0 selects 16 clocks per bit |
| cfg_len_m1 | input | 3 | Data bits per character minus one |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 odd parity, 0 even parity |
| cfg_two_stop | input | 1 | 1 two stop bits, 0 one stop bit |
| cfg_addr_mode | input | 1 | 1 tag-bit address mode, 0 idle-gap address mode |
| sleep | input | 1 | Deliver only address frames |
| rd_ack | input | 1 | Character taken; clears rx_full and rx_overrun |
| rx_data | output | 8 | Received character, right-aligned |
| rx_ready | output | 1 | One-cycle strobe when a character is delivered |
| rx_full | output | 1 | Unread character held |
| rx_addr | output | 1 | Delivered character was an address frame |
| rx_par_err | output | 1 | Parity error of the delivered character |
| rx_frm_err | output | 1 | Framing error of the delivered character |
| rx_overrun | output | 1 | Sticky overrun flag |

## Verification
The latency from the line's falling edge to rx_ready is known exactly:

- two synchroniser stages and the edge register take 3 clocks;
- the start-bit centre follows half a bit period later;
- each further bit adds one full period;
- the delivery register adds one clock.

The bench records the clock cycle in which it drives each start bit low. It compares the cycle of the rx_ready strobe with 4 + P/2 + (F-1)*P from that point.

Character, flags and rx_full are read at the falling clock edge after the last stop bit has been fully driven, which is later than the strobe. Discarded frames are checked at the same point: the bench confirms that the pulse count, rx_data and rx_full are unchanged.

// File: rtl/uart_addr_rx_pkg.sv
package uart_addr_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_TAG,
        ST_STOP1,
        ST_STOP2
    } rx_state_e;

    typedef struct packed {
        logic [2:0] len_m1;
        logic       par_en;
        logic       par_odd;
        logic       two_stop;
        logic       addr_mode;
    } rx_cfg_t;

    typedef struct packed {
        logic [7:0] data;
        logic       par_err;
        logic       frm_err;
        logic       tag_bit;
        logic       after_idle;
    } rx_frame_t;

    // Clocks per bit for a given baud setting.
    function automatic logic [31:0] period_of(input logic [31:0] baud);
        return (baud == 32'd0) ? 32'd16 : ((baud + 32'd1) << 3);
    endfunction

    // Parity bit the sender should have placed after the data.
    function automatic logic parity_expect(input logic [7:0] d, input logic odd);
        return odd ? ~(^d) : (^d);
    endfunction

    // The shift register fills from the top; move the character down.
    function automatic logic [7:0] align(input logic [7:0] sh, input logic [2:0] len_m1);
        return sh >> (3'd7 - len_m1);
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rxd,
    output logic line,
    output logic fall
);
    logic [STAGES:0] q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '1;
        end else begin
            q <= {q[STAGES-1:0], rxd};
        end
    end

    assign line = q[STAGES-1];
    assign fall = q[STAGES] & ~q[STAGES-1];
endmodule

// File: rtl/uart_rx_idle.sv
module uart_rx_idle #(
    parameter int CNT_W     = 12,
    parameter int IDLE_BITS = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             line,
    input  logic [CNT_W-1:0] period,
    output logic             idle_ok
);
    localparam int BW = $clog2(IDLE_BITS + 1);
    localparam logic [BW-1:0] FULL = BW'(IDLE_BITS);

    logic [CNT_W-1:0] clk_cnt;
    logic [BW-1:0]    bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_cnt <= '0;
            bits    <= '0;
        end else if (!enable || !line) begin
            clk_cnt <= '0;
            bits    <= '0;
        end else if (clk_cnt == period - CNT_W'(1)) begin
            clk_cnt <= '0;
            if (bits != FULL) begin
                bits <= bits + BW'(1);
            end
        end else begin
            clk_cnt <= clk_cnt + CNT_W'(1);
        end
    end

    assign idle_ok = (bits == FULL);

    assert_idle_sat_R8: assert property (@(posedge clk) disable iff (rst)
        (bits == FULL && enable && line) |=> (bits == FULL));
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_addr_rx_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line,
    input  logic             fall,
    input  logic [CNT_W-1:0] period,
    input  rx_cfg_t          cfg,
    input  logic             idle_ok,
    output logic             busy,
    output logic             done,
    output rx_frame_t        result
);
    rx_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic [2:0]       bitidx;
    logic [7:0]       shreg;
    logic             par_bit;
    logic             tag;
    logic             ferr;
    logic             after_idle;

    logic [CNT_W-1:0] half;
    logic             at_centre;
    logic             at_bit;
    logic [7:0]       data_al;
    logic             par_bad;
    rx_state_e        after_data;
    rx_state_e        after_par;

    assign half      = period >> 1;
    assign at_centre = (cnt == half - CNT_W'(1));
    assign at_bit    = (cnt == period - CNT_W'(1));
    assign data_al   = align(shreg, cfg.len_m1);
    assign par_bad   = cfg.par_en && (par_bit != parity_expect(data_al, cfg.par_odd));
    assign after_par = cfg.addr_mode ? ST_TAG : ST_STOP1;
    assign after_data = cfg.par_en ? ST_PAR : after_par;
    assign busy      = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            bitidx     <= '0;
            shreg      <= '0;
            par_bit    <= 1'b0;
            tag        <= 1'b0;
            ferr       <= 1'b0;
            after_idle <= 1'b0;
            done       <= 1'b0;
            result     <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (fall) begin
                        state      <= ST_START;
                        cnt        <= '0;
                        after_idle <= idle_ok;
                        ferr       <= 1'b0;
                    end
                end
                ST_START: begin
                    if (at_centre) begin
                        cnt    <= '0;
                        bitidx <= '0;
                        state  <= line ? ST_IDLE : ST_DATA;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: begin
                    if (at_bit) begin
                        cnt <= '0;
                        case (state)
                            ST_DATA: begin
                                shreg <= {line, shreg[7:1]};
                                if (bitidx == cfg.len_m1) begin
                                    state <= after_data;
                                end else begin
                                    bitidx <= bitidx + 3'd1;
                                end
                            end
                            ST_PAR: begin
                                par_bit <= line;
                                state   <= after_par;
                            end
                            ST_TAG: begin
                                tag   <= line;
                                state <= ST_STOP1;
                            end
                            ST_STOP1: begin
                                if (cfg.two_stop) begin
                                    ferr  <= ~line;
                                    state <= ST_STOP2;
                                end else begin
                                    state  <= ST_IDLE;
                                    done   <= 1'b1;
                                    result <= '{data: data_al, par_err: par_bad,
                                                frm_err: ~line, tag_bit: tag,
                                                after_idle: after_idle};
                                end
                            end
                            default: begin
                                state  <= ST_IDLE;
                                done   <= 1'b1;
                                result <= '{data: data_al, par_err: par_bad,
                                            frm_err: ferr | ~line, tag_bit: tag,
                                            after_idle: after_idle};
                            end
                        endcase
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
            endcase
        end
    end

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt < period));

    assert_glitch_abort_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_START && at_centre && line) |=> (state == ST_IDLE && !done));
endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx
    import uart_addr_rx_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int IDLE_BITS = 10,
    parameter int SYNC_N    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rxd,
    input  logic [DIV_W-1:0] cfg_baud,
    input  logic [2:0]       cfg_len_m1,
    input  logic             cfg_par_en,
    input  logic             cfg_par_odd,
    input  logic             cfg_two_stop,
    input  logic             cfg_addr_mode,
    input  logic             sleep,
    input  logic             rd_ack,
    output logic [7:0]       rx_data,
    output logic             rx_ready,
    output logic             rx_full,
    output logic             rx_addr,
    output logic             rx_par_err,
    output logic             rx_frm_err,
    output logic             rx_overrun
);
    localparam int CNT_W = DIV_W + 4;

    rx_cfg_t          cfg;
    logic [CNT_W-1:0] period;
    logic             line;
    logic             fall;
    logic             busy;
    logic             idle_ok;
    logic             frame_done;
    rx_frame_t        frame;
    logic             is_addr;
    logic             deliver;

    assign cfg = '{len_m1: cfg_len_m1, par_en: cfg_par_en, par_odd: cfg_par_odd,
                   two_stop: cfg_two_stop, addr_mode: cfg_addr_mode};
    assign period = CNT_W'(period_of(32'(cfg_baud)));

    uart_rx_sync #(.STAGES(SYNC_N)) u_sync (
        .clk (clk),
        .rst (rst),
        .rxd (rxd),
        .line(line),
        .fall(fall)
    );

    uart_rx_idle #(.CNT_W(CNT_W), .IDLE_BITS(IDLE_BITS)) u_idle (
        .clk    (clk),
        .rst    (rst),
        .enable (~busy),
        .line   (line),
        .period (period),
        .idle_ok(idle_ok)
    );

    uart_rx_frame #(.CNT_W(CNT_W)) u_frame (
        .clk    (clk),
        .rst    (rst),
        .line   (line),
        .fall   (fall),
        .period (period),
        .cfg    (cfg),
        .idle_ok(idle_ok),
        .busy   (busy),
        .done   (frame_done),
        .result (frame)
    );

    assign is_addr = cfg_addr_mode ? frame.tag_bit : frame.after_idle;
    assign deliver = frame_done && (!sleep || is_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data    <= '0;
            rx_ready   <= 1'b0;
            rx_full    <= 1'b0;
            rx_addr    <= 1'b0;
            rx_par_err <= 1'b0;
            rx_frm_err <= 1'b0;
            rx_overrun <= 1'b0;
        end else begin
            rx_ready <= deliver;
            if (deliver) begin
                rx_data    <= frame.data;
                rx_addr    <= is_addr;
                rx_par_err <= frame.par_err;
                rx_frm_err <= frame.frm_err;
                rx_full    <= 1'b1;
            end else if (rd_ack) begin
                rx_full <= 1'b0;
            end
            if (deliver && rx_full && !rd_ack) begin
                rx_overrun <= 1'b1;
            end else if (rd_ack) begin
                rx_overrun <= 1'b0;
            end
        end
    end

    assert_ready_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        rx_ready |=> !rx_ready);

    assert_ready_full_R2: assert property (@(posedge clk) disable iff (rst)
        rx_ready |-> rx_full);

    assert_sleep_drop_R9: assert property (@(posedge clk) disable iff (rst)
        (frame_done && sleep && !is_addr) |=> (!rx_ready && $stable(rx_data)));

    assert_awake_pass_R10: assert property (@(posedge clk) disable iff (rst)
        (frame_done && !sleep) |=> rx_ready);

    assert_overrun_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (rx_overrun && !rd_ack) |=> rx_overrun);

    assert_overrun_cause_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_overrun) |-> $past(rx_full));
endmodule

// File: tb/uart_addr_rx_tb.sv
module uart_addr_rx_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             rxd = 1'b1;
    logic [DIV_W-1:0] cfg_baud = '0;
    logic [2:0]       cfg_len_m1 = 3'd7;
    logic             cfg_par_en = 1'b0;
    logic             cfg_par_odd = 1'b0;
    logic             cfg_two_stop = 1'b0;
    logic             cfg_addr_mode = 1'b1;
    logic             sleep = 1'b0;
    logic             rd_ack = 1'b0;
    logic [7:0]       rx_data;
    logic             rx_ready, rx_full, rx_addr, rx_par_err, rx_frm_err, rx_overrun;

    uart_addr_rx #(.DIV_W(DIV_W)) u_dut (
        .clk(clk), .rst(rst), .rxd(rxd), .cfg_baud(cfg_baud),
        .cfg_len_m1(cfg_len_m1), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_two_stop(cfg_two_stop), .cfg_addr_mode(cfg_addr_mode), .sleep(sleep),
        .rd_ack(rd_ack), .rx_data(rx_data), .rx_ready(rx_ready), .rx_full(rx_full),
        .rx_addr(rx_addr), .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err),
        .rx_overrun(rx_overrun)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int pulses = 0;
    int last_rise = -1;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (rx_ready) begin pulses++; last_rise = cyc; end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int per();
        return (cfg_baud == 0) ? 16 : (int'(cfg_baud) + 1) * 8;
    endfunction

    function automatic int nbits();
        return 1 + int'(cfg_len_m1) + 1 + int'(cfg_par_en) + int'(cfg_addr_mode)
               + (cfg_two_stop ? 2 : 1);
    endfunction

    function automatic logic [7:0] mask();
        return 8'hFF >> (3'd7 - cfg_len_m1);
    endfunction

    task automatic hold_bit(input logic v);
        rxd = v;
        repeat (per()) @(negedge clk);
    endtask

    task automatic idle_bits(input int n);
        rxd = 1'b1;
        repeat (n * per()) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input bit tagb, input bit flip_par,
                        input bit bad_stop, output int t0);
        logic [7:0] dm;
        logic pb;
        dm = d & mask();
        t0 = cyc;
        hold_bit(1'b0);
        for (int i = 0; i <= int'(cfg_len_m1); i++) hold_bit(dm[i]);
        if (cfg_par_en) begin
            pb = cfg_par_odd ? ~(^dm) : (^dm);
            hold_bit(pb ^ flip_par);
        end
        if (cfg_addr_mode) hold_bit(tagb);
        hold_bit(~bad_stop);
        if (cfg_two_stop) hold_bit(1'b1);
        rxd = 1'b1;
    endtask

    task automatic do_read();
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
    endtask

    task automatic expect_frame(input string atag, input int p0, input int t0,
                                input logic [7:0] d, input bit pe, input bit fe,
                                input bit ad, input bit rd_after);
        int exp_rise;
        exp_rise = t0 + 4 + per() / 2 + (nbits() - 1) * per();
        chk(pulses == p0 + 1, "R2 ready pulse count", pulses, p0 + 1);
        chk(last_rise == exp_rise, "R3 ready cycle", last_rise, exp_rise);
        chk(rx_data == (d & mask()), "R2 data", rx_data, d & mask());
        chk(rx_full == 1'b1, "R2 full", rx_full, 1);
        chk(rx_par_err == pe, "R4 parity flag", rx_par_err, pe);
        chk(rx_frm_err == fe, "R5 framing flag", rx_frm_err, fe);
        chk(rx_addr == ad, atag, rx_addr, ad);
        if (rd_after) begin
            do_read();
            chk(rx_full == 1'b0, "R2 full cleared by read", rx_full, 0);
        end
    endtask

    initial begin
        int t0, p0;
        logic [7:0] d, prev;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(rx_ready == 0 && rx_full == 0 && rx_overrun == 0, "R1 flags", rx_full, 0);
        chk(rx_par_err == 0 && rx_frm_err == 0 && rx_addr == 0, "R1 errors", rx_par_err, 0);
        chk(rx_data == 8'h00, "R1 data", rx_data, 0);
        idle_bits(2);

        // Sweep: all lengths, parity modes, stop counts, tag values (R2 R3 R4 R7 R10)
        cfg_addr_mode = 1'b1;
        for (int len = 1; len <= 8; len++) begin
            for (int pm = 0; pm < 3; pm++) begin
                for (int st = 0; st < 2; st++) begin
                    for (int k = 0; k < 3; k++) begin
                        cfg_len_m1 = 3'(len - 1);
                        cfg_par_en = (pm != 0);
                        cfg_par_odd = (pm == 2);
                        cfg_two_stop = st[0];
                        d = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'((len * 37 + 11 + pm * 5) & 255);
                        p0 = pulses;
                        send(d, k[0], 1'b0, 1'b0, t0);
                        expect_frame("R7 tag flag", p0, t0, d, 1'b0, 1'b0, k[0], 1'b1);
                        idle_bits(1);
                    end
                end
            end
        end

        // Slower rate, parity errors injected on alternate characters (R3 R4)
        cfg_baud = 8'd2;
        cfg_len_m1 = 3'd7;
        cfg_par_en = 1'b1;
        cfg_two_stop = 1'b0;
        for (int v = 0; v < 16; v++) begin
            cfg_par_odd = v[1];
            d = 8'(v * 17 + 3);
            p0 = pulses;
            send(d, 1'b0, v[0], 1'b0, t0);
            expect_frame("R7 tag flag", p0, t0, d, v[0], 1'b0, 1'b0, 1'b1);
            idle_bits(1);
        end

        // Framing errors, one and two stop bits (R5)
        cfg_baud = 8'd0;
        cfg_par_en = 1'b0;
        for (int st = 0; st < 2; st++) begin
            cfg_two_stop = st[0];
            p0 = pulses;
            send(8'hA5, 1'b0, 1'b0, 1'b1, t0);
            expect_frame("R7 tag flag", p0, t0, 8'hA5, 1'b0, 1'b1, 1'b0, 1'b1);
            idle_bits(1);
        end
        cfg_two_stop = 1'b0;

        // Start glitch rejected, then a normal frame (R6)
        p0 = pulses;
        rxd = 1'b0;
        repeat (3) @(negedge clk);
        rxd = 1'b1;
        idle_bits(2);
        chk(pulses == p0, "R6 glitch no ready", pulses, p0);
        chk(rx_full == 1'b0, "R6 glitch full", rx_full, 0);
        p0 = pulses;
        send(8'h3C, 1'b1, 1'b0, 1'b0, t0);
        expect_frame("R6 frame after glitch", p0, t0, 8'h3C, 1'b0, 1'b0, 1'b1, 1'b1);
        idle_bits(1);

        // Sleep in tag mode (R9 R10)
        sleep = 1'b1;
        prev = rx_data;
        p0 = pulses;
        send(8'h11, 1'b0, 1'b0, 1'b0, t0);
        idle_bits(1);
        chk(pulses == p0, "R9 data frame dropped (ready)", pulses, p0);
        chk(rx_data == prev, "R9 data frame dropped (data)", rx_data, prev);
        chk(rx_full == 1'b0, "R9 data frame dropped (full)", rx_full, 0);
        p0 = pulses;
        send(8'h42, 1'b1, 1'b0, 1'b0, t0);
        expect_frame("R9 address passes sleep", p0, t0, 8'h42, 1'b0, 1'b0, 1'b1, 1'b1);
        sleep = 1'b0;
        idle_bits(1);
        p0 = pulses;
        send(8'h99, 1'b0, 1'b0, 1'b0, t0);
        expect_frame("R10 data after wake", p0, t0, 8'h99, 1'b0, 1'b0, 1'b0, 1'b1);

        // Idle-gap mode (R8)
        cfg_addr_mode = 1'b0;
        idle_bits(12);
        p0 = pulses;
        send(8'h5A, 1'b0, 1'b0, 1'b0, t0);
        expect_frame("R8 long gap address", p0, t0, 8'h5A, 1'b0, 1'b0, 1'b1, 1'b1);
        idle_bits(2);
        p0 = pulses;
        send(8'h6B, 1'b0, 1'b0, 1'b0, t0);
        expect_frame("R8 short gap data", p0, t0, 8'h6B, 1'b0, 1'b0, 1'b0, 1'b1);
        // Sleep with idle-gap detection (R9)
        sleep = 1'b1;
        idle_bits(2);
        prev = rx_data;
        p0 = pulses;
        send(8'h77, 1'b0, 1'b0, 1'b0, t0);
        chk(pulses == p0, "R9 idle-mode data dropped", pulses, p0);
        chk(rx_data == prev, "R9 idle-mode data kept", rx_data, prev);
        idle_bits(12);
        p0 = pulses;
        send(8'h0F, 1'b0, 1'b0, 1'b0, t0);
        expect_frame("R9 idle-mode address passes", p0, t0, 8'h0F, 1'b0, 1'b0, 1'b1, 1'b1);
        sleep = 1'b0;

        // Overrun (R11)
        idle_bits(2);
        p0 = pulses;
        send(8'h21, 1'b0, 1'b0, 1'b0, t0);
        expect_frame("R8 short gap data", p0, t0, 8'h21, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(rx_overrun == 1'b0, "R11 no overrun on first", rx_overrun, 0);
        idle_bits(2);
        p0 = pulses;
        send(8'hC4, 1'b0, 1'b0, 1'b0, t0);
        expect_frame("R8 short gap data", p0, t0, 8'hC4, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(rx_overrun == 1'b1, "R11 overrun set", rx_overrun, 1);
        idle_bits(1);
        chk(rx_overrun == 1'b1, "R11 overrun sticky", rx_overrun, 1);
        do_read();
        chk(rx_overrun == 1'b0, "R11 overrun cleared by read", rx_overrun, 0);
        chk(rx_full == 1'b0, "R11 full cleared by read", rx_full, 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule